// File: doc/BRIEF.md
# Pipelined Processor Bus Cycle Tracker

This block sits on the host side of a pipelined processor bus that allows two bus cycles to be in flight at once. The processor opens each cycle with an address strobe that carries a cycle kind. The tracker keeps those cycles in a two-entry queue, oldest at the head. It answers each data transfer of the head cycle with a burst-ready. A burst-ready means one of three things: read data is on the bus, write data has been taken, or a special cycle has been acknowledged. When the memory side can take another address while one cycle is still open, the tracker gives a one-clock early next-address pulse. This lets the processor start its next cycle before the current one finishes.

Memory timing, address decoding and data buffering are outside the block. They reach it as two inputs: `mem_addr_ready` says the memory side can take an address, and `data_ack` says the memory side has finished one transfer. A backoff input makes the processor give up the bus. It aborts every cycle that has not finished, and the processor issues those cycles again after backoff is released. The tracker reports how many cycles are queued and the kind of the head cycle.

Top module: `bus_cycle_tracker`

## Requirements
- R1: `next_addr` is high in the same clock as `mem_addr_ready` only if all of these hold: exactly one cycle is queued, `backoff` is low, and no pulse has been given yet for the current head. It therefore lasts one clock, even while `mem_addr_ready` stays high.
- R2: An `addr_strobe` is accepted when fewer than two cycles are queued, including two clocks after a `next_addr` pulse. With two cycles queued it is accepted only if the head completes in that same clock; otherwise it is ignored.
- R3: No more than two cycles are ever queued, and `next_addr` never rises while two are queued.
- R4: `burst_rdy` follows `data_ack` in the same clock when at least one cycle is queued and `backoff` is low. A `data_ack` with an empty queue gives no `burst_rdy`.
- R5: In every clock where `backoff` is sampled high, all queued cycles are dropped: `q_count` reads 0 after that edge. An `addr_strobe` during backoff is ignored.
- R6: While `backoff` is high, neither `burst_rdy` nor `next_addr` is asserted.
- R7: The cycle kind is encoded as 0 single read, 1 single write, 2 burst read, 3 burst write, 4 special. Kinds 2 and 3 complete on their fourth `burst_rdy`. All other codes, including the unused codes 5 to 7, complete on their first.
- R8: When the head completes, it is retired and the second entry becomes the head at the same edge. `q_count` and `head_kind` show this after the edge. `head_kind` reads 0 when the queue is empty.
- R9: After backoff is released, a reissued burst counts its transfers from zero. A burst cut off by backoff part-way through still needs four fresh transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_strobe | input | 1 | Processor starts a bus cycle |
| cycle_kind | input | 3 | Kind of the cycle being started (R7 encoding) |
| mem_addr_ready | input | 1 | Memory side can take a new address |
| data_ack | input | 1 | Memory side finished one transfer |
| backoff | input | 1 | Abort all open cycles and keep the processor off the bus |
| next_addr | output | 1 | One-clock early next-address pulse |
| burst_rdy | output | 1 | Transfer complete for the head cycle |
| q_count | output | 2 | Number of queued cycles, 0 to 2 |
| head_kind | output | 3 | Kind of the head cycle, 0 when empty |

## Verification
A wrong beat count shows at the ports on the transfer where it goes wrong. The head retires too early or too late, so `q_count` and `head_kind` differ from the expected values one edge after that `burst_rdy`. A stale next-address flag shows as a repeated or missing `next_addr` in the next clock where `mem_addr_ready` is high with one cycle queued. A queue that is not cleared by backoff shows one edge after backoff is first sampled, as a nonzero `q_count`. The same fault also surfaces later, when the reissued burst completes too soon.

// File: rtl/bct_pkg.sv
package bct_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    K_RD1  = 3'd0,
    K_WR1  = 3'd1,
    K_RD4  = 3'd2,
    K_WR4  = 3'd3,
    K_SPEC = 3'd4
  } kind_e;

  // transfers needed before a cycle of kind k is complete
  function automatic int beats_for(input logic [KIND_W-1:0] k, input int blen);
    if (k == K_RD4 || k == K_WR4) return blen;
    return 1;
  endfunction
endpackage

// File: rtl/bct_queue.sv
module bct_queue
  import bct_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [KIND_W-1:0] push_kind,
  input  logic              pop,
  output logic [CW-1:0]     count,
  output logic [KIND_W-1:0] head_kind,
  output logic [KIND_W-1:0] second_kind
);
  logic [KIND_W-1:0] slot_q [DEPTH];
  logic [KIND_W-1:0] shift_in [DEPTH];
  logic [CW-1:0]     count_q;
  logic [CW-1:0]     wr_idx;

  assign wr_idx = count_q - CW'(pop);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i + 1 < DEPTH) begin : g_mid
      assign shift_in[i] = slot_q[i+1];
    end else begin : g_last
      assign shift_in[i] = '0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n || flush)                 slot_q[i] <= '0;
      else if (push && wr_idx == CW'(i))   slot_q[i] <= push_kind;
      else if (pop)                        slot_q[i] <= shift_in[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) count_q <= '0;
    else                 count_q <= count_q + CW'(push) - CW'(pop);
  end

  assign count       = count_q;
  assign head_kind   = (count_q != '0) ? slot_q[0] : '0;
  assign second_kind = (DEPTH > 1) ? slot_q[DEPTH > 1 ? 1 : 0] : '0;

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush) |-> (count_q < CW'(DEPTH)));
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count_q != '0));
endmodule

// File: rtl/bct_beat_counter.sv
module bct_beat_counter
  import bct_pkg::*;
#(
  parameter int BURST_LEN = 4,
  localparam int BW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              beat,
  input  logic [KIND_W-1:0] head_kind,
  output logic              last_beat,
  output logic [BW-1:0]     beat_idx
);
  logic [BW-1:0] idx_q;

  assign last_beat = beat && (int'(idx_q) == beats_for(head_kind, BURST_LEN) - 1);
  assign beat_idx  = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear)  idx_q <= '0;
    else if (last_beat)   idx_q <= '0;
    else if (beat)        idx_q <= idx_q + BW'(1);
  end

  p_beat_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx_q) < beats_for(head_kind, BURST_LEN));
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (idx_q == '0));
endmodule

// File: rtl/bct_na_gen.sv
module bct_na_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic backoff,
  input  logic mem_ready,
  input  logic one_open,
  input  logic head_retired,
  output logic next_addr
);
  logic given_q;

  assign next_addr = mem_ready && one_open && !backoff && !given_q;

  always_ff @(posedge clk) begin
    if (!rst_n || backoff || head_retired) given_q <= 1'b0;
    else if (next_addr)                    given_q <= 1'b1;
  end

  p_na_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (next_addr && !head_retired) |=> !next_addr);
endmodule

// File: rtl/bus_cycle_tracker.sv
module bus_cycle_tracker
  import bct_pkg::*;
#(
  parameter int DEPTH     = 2,
  parameter int BURST_LEN = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int BW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_strobe,
  input  logic [KIND_W-1:0] cycle_kind,
  input  logic              mem_addr_ready,
  input  logic              data_ack,
  input  logic              backoff,
  output logic              next_addr,
  output logic              burst_rdy,
  output logic [CW-1:0]     q_count,
  output logic [KIND_W-1:0] head_kind
);
  // named internal events
  logic              cycle_done;
  logic              strobe_taken;
  logic              queue_nonempty;
  logic              queue_full;
  logic [KIND_W-1:0] second_kind;
  logic [BW-1:0]     beat_idx;

  assign queue_nonempty = (q_count != '0);
  assign queue_full     = (q_count == CW'(DEPTH));
  assign burst_rdy      = data_ack && queue_nonempty && !backoff;
  assign strobe_taken   = addr_strobe && !backoff && (!queue_full || cycle_done);

  bct_queue #(.DEPTH(DEPTH)) u_queue (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (backoff),
    .push        (strobe_taken),
    .push_kind   (cycle_kind),
    .pop         (cycle_done),
    .count       (q_count),
    .head_kind   (head_kind),
    .second_kind (second_kind)
  );

  bct_beat_counter #(.BURST_LEN(BURST_LEN)) u_beats (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (backoff),
    .beat      (burst_rdy),
    .head_kind (head_kind),
    .last_beat (cycle_done),
    .beat_idx  (beat_idx)
  );

  bct_na_gen u_na (
    .clk          (clk),
    .rst_n        (rst_n),
    .backoff      (backoff),
    .mem_ready    (mem_addr_ready),
    .one_open     (q_count == CW'(1)),
    .head_retired (cycle_done),
    .next_addr    (next_addr)
  );

  p_quiet_backoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
    backoff |-> (!burst_rdy && !next_addr));
  p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    backoff |=> (q_count == '0));
  p_na_not_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    queue_full |-> !next_addr);
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_taken && !cycle_done) |=> (q_count == $past(q_count) + CW'(1)));
  p_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_done && queue_full && !addr_strobe) |=>
      (q_count == CW'(DEPTH - 1) && head_kind == $past(second_kind)));
  p_beats_only_when_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    burst_rdy |-> (q_count != '0 && data_ack));
endmodule

// File: tb/bus_cycle_tracker_test.sv
`timescale 1ns/1ps
module bus_cycle_tracker_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       addr_strobe, mem_addr_ready, data_ack, backoff;
  logic [2:0] cycle_kind;
  logic       next_addr, burst_rdy;
  logic [1:0] q_count;
  logic [2:0] head_kind;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  // scoreboard of expected open cycles, oldest first
  logic [2:0] sb[$];
  int         beat_m  = 0;
  bit         given_m = 0;

  always #2.5 clk = ~clk;

  bus_cycle_tracker uut (
    .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe), .cycle_kind(cycle_kind),
    .mem_addr_ready(mem_addr_ready), .data_ack(data_ack), .backoff(backoff),
    .next_addr(next_addr), .burst_rdy(burst_rdy), .q_count(q_count), .head_kind(head_kind)
  );

  function automatic int need(input logic [2:0] k);
    return (k == 3'd2 || k == 3'd3) ? 4 : 1;
  endfunction

  task automatic chk(input int act, input int exp, input string tag, input string what);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic ads, input logic [2:0] k, input logic mar,
                      input logic ack, input logic boff, input string tag);
    logic exp_br, exp_na, done_m, acc_m;
    @(negedge clk);
    addr_strobe = ads; cycle_kind = k; mem_addr_ready = mar; data_ack = ack; backoff = boff;
    #1;
    exp_br = ack && (sb.size() != 0) && !boff;
    exp_na = mar && !boff && (sb.size() == 1) && !given_m;
    done_m = exp_br && (beat_m == need(sb[0]) - 1);
    acc_m  = ads && !boff && (sb.size() < 2 || done_m);
    chk(int'(burst_rdy), int'(exp_br), tag, "burst_rdy");
    chk(int'(next_addr), int'(exp_na), tag, "next_addr");
    if (done_m) chk(int'(head_kind), int'(sb[0]), tag, "retiring kind");
    @(posedge clk);
    if (boff) begin
      sb.delete(); beat_m = 0; given_m = 0;
    end else begin
      if (done_m) begin void'(sb.pop_front()); beat_m = 0; end
      else if (exp_br) beat_m++;
      if (acc_m) sb.push_back(k);
      given_m = done_m ? 1'b0 : (exp_na ? 1'b1 : given_m);
    end
    #1;
    chk(int'(q_count), sb.size(), tag, "q_count");
    chk(int'(head_kind), (sb.size() != 0) ? int'(sb[0]) : 0, tag, "head_kind");
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr_strobe = 0; cycle_kind = 0; mem_addr_ready = 0; data_ack = 0; backoff = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(int'(q_count), 0, "R8 reset", "q_count");
    chk(int'(head_kind), 0, "R8 reset", "head_kind");
    chk(int'(next_addr), 0, "R1 reset", "next_addr");
    chk(int'(burst_rdy), 0, "R4 reset", "burst_rdy");

    step(0, 3'd0, 0, 1, 0, "R4");            // ack with empty queue
    step(1, 3'd0, 0, 0, 0, "R2");            // single read opens
    step(0, 3'd0, 1, 0, 0, "R1");            // early next-address pulse
    step(0, 3'd0, 1, 0, 0, "R1");            // ready held: no second pulse
    step(1, 3'd2, 0, 0, 0, "R2");            // burst read two clocks after pulse
    step(0, 3'd0, 1, 0, 0, "R3");            // full: no pulse
    step(1, 3'd1, 0, 0, 0, "R3");            // full: strobe ignored
    step(0, 3'd0, 0, 1, 0, "R8");            // single read retires, burst moves up
    for (int i = 0; i < 4; i++) step(0, 3'd0, 0, 1, 0, "R7");

    step(1, 3'd1, 0, 0, 0, "R2");
    step(1, 3'd4, 0, 0, 0, "R2");
    step(1, 3'd5, 0, 1, 0, "R2");            // full, head done, strobe taken
    step(0, 3'd0, 0, 1, 0, "R7");            // special: one transfer
    step(0, 3'd0, 0, 1, 0, "R7");            // code 5: one transfer

    step(1, 3'd3, 0, 0, 0, "R9");
    step(0, 3'd0, 0, 1, 0, "R9");
    step(0, 3'd0, 0, 1, 0, "R9");
    step(1, 3'd4, 1, 1, 0, "R1");            // pulse and second strobe mid-burst
    step(1, 3'd0, 1, 1, 1, "R6");            // backoff silences everything
    step(0, 3'd0, 1, 1, 1, "R5");            // held backoff, queue empty
    step(1, 3'd3, 0, 0, 0, "R9");            // reissued burst write
    for (int i = 0; i < 4; i++) step(0, 3'd0, 0, 1, 0, "R9");
    step(1, 3'd4, 1, 1, 0, "R8");
    step(0, 3'd0, 0, 0, 0, "R8");

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule